// File: doc/BRIEF.md
# Stepped Stereo Digital Volume with Ramp

The block scales a stereo stream of signed audio samples by a per-channel attenuation chosen with an 8-bit logarithmic code. Both channel codes arrive together in one 16-bit control word. Each code selects a gain from a synthesizable decibel-to-linear lookup, the sample is multiplied by it, rounded and saturated. The top code band silences the channel completely.

With the ramp input high, a newly written code is not applied at once. Instead the applied setting walks one step per input sample toward the target, so a large volume change becomes a smooth fade. With the ramp input low, the new setting is applied to the first sample strobed after the write. Each scaled sample appears one clock after its input strobe.

Top module: `stereo_vol_ramp`

## Requirements
- R1: After reset `valid_o`, `left_o` and `right_o` are 0 and both channels' applied setting is 0 dB (code 0x3C), so a first sample with ramping on and code 0x3C on both channels passes unchanged.
- R2: `vol_word_i[7:0]` is the left-channel code and `vol_word_i[15:8]` the right-channel code; each channel is scaled only by its own code.
- R3: For an applied code c from 0x3C to 0xF0 the gain is g = round(32768 * 10^(-0.5017*(c-0x3C)/20)) in unsigned Q1.15, and the output is floor((x*g + 16384) / 32768) saturated to the signed sample range.
- R4: Codes 0x00 to 0x3B are applied as 0x3C (0 dB).
- R5: Codes 0xF1 to 0xFB are applied as 0xF0 (about -90 dB).
- R6: Codes 0xFC to 0xFF mute the channel: the output sample is exactly 0.
- R7: With `ramp_en_i` low, a strobed sample is scaled by the code present on `vol_word_i` in that same cycle.
- R8: With `ramp_en_i` high, each strobe moves the applied setting one step toward the target before scaling that sample; once equal it stays.
- R9: A ramp into mute passes through -90 dB (0xF0) on the step before the zero output; a ramp out of mute first applies -90 dB.
- R10: Without a strobe the applied settings do not change and the outputs hold their last values, whatever the control word does.
- R11: `valid_o` is high exactly in the cycle after each cycle with `valid_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| left_i | input | 16 | Left input sample, signed |
| right_i | input | 16 | Right input sample, signed |
| vol_word_i | input | 16 | Volume codes: right in [15:8], left in [7:0] |
| ramp_en_i | input | 1 | 1 = step toward new codes, 0 = jump |
| valid_o | output | 1 | Output sample strobe |
| left_o | output | 16 | Left output sample, signed |
| right_o | output | 16 | Right output sample, signed |

## Verification
The two functions that share a cycle are a change of the control word and the step of the applied setting caused by a strobe: the bench rewrites the codes in the very cycle it strobes, including a reversal of direction in mid-ramp and toggling of the ramp input. A model that advances the applied setting first and then scales the sample predicts each output. The full code range is swept with several sample values, including both full-scale extremes, and idle gaps with a changing control word confirm that nothing moves between strobes.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int DEF_SAMPLE_W = 16;
  localparam int DEF_CODE_W   = 8;
  localparam int DEF_GAIN_W   = 16;
  localparam int DEF_FRAC_W   = 15;
  localparam int DEF_UNITY    = 'h3C;
  localparam int DEF_FLOOR    = 'hF0;
  localparam int DEF_MUTE     = 'hFC;
  localparam real DEF_STEP_DB = 0.5017;

  // Q(frac) gain for idx steps below unity, rounded to nearest
  function automatic int unsigned db_gain(int unsigned idx, real step_db, int frac_w);
    real lin;
    lin = $pow(10.0, -(step_db * real'(idx)) / 20.0);
    return int'($rtoi(lin * real'(64'd1 << frac_w) + 0.5));
  endfunction
endpackage

// File: rtl/vol_gain_lut.sv
module vol_gain_lut
  import vol_pkg::*;
#(
  parameter int  GAIN_W  = DEF_GAIN_W,
  parameter int  FRAC_W  = DEF_FRAC_W,
  parameter int  STEPS   = DEF_FLOOR - DEF_UNITY + 1,
  parameter real STEP_DB = DEF_STEP_DB,
  parameter int  IDX_W   = $clog2(STEPS + 1)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              mute_o
);
  logic [GAIN_W-1:0] tab [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_tab
    localparam int unsigned G = db_gain(i, STEP_DB, FRAC_W);
    assign tab[i] = GAIN_W'(G);
  end

  always_comb begin
    mute_o = (int'(idx_i) >= STEPS);
    gain_o = mute_o ? '0 : tab[idx_i];
  end
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp
  import vol_pkg::*;
#(
  parameter int CODE_W     = DEF_CODE_W,
  parameter int UNITY_CODE = DEF_UNITY,
  parameter int FLOOR_CODE = DEF_FLOOR,
  parameter int MUTE_CODE  = DEF_MUTE,
  parameter int FLOOR_IDX  = FLOOR_CODE - UNITY_CODE,
  parameter int MUTE_IDX   = FLOOR_IDX + 1,
  parameter int IDX_W      = $clog2(MUTE_IDX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ramp_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] tgt, cur_q, cur_d;

  // code -> step index; reserved low band = 0 dB, upper gap = floor, top = mute
  always_comb begin
    if (int'(code_i) < UNITY_CODE)       tgt = '0;
    else if (int'(code_i) >= MUTE_CODE)  tgt = IDX_W'(MUTE_IDX);
    else if (int'(code_i) > FLOOR_CODE)  tgt = IDX_W'(FLOOR_IDX);
    else                                 tgt = IDX_W'(int'(code_i) - UNITY_CODE);
  end

  always_comb begin
    cur_d = cur_q;
    if (!ramp_en_i)        cur_d = tgt;
    else if (cur_q < tgt)  cur_d = cur_q + 1'b1;
    else if (cur_q > tgt)  cur_d = cur_q - 1'b1;
  end

  // strobed sample uses the already advanced setting
  assign idx_o = cur_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= '0;
    else if (valid_i) cur_q <= cur_d;
  end

  AST_RAMP_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ramp_en_i) |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) + 1'b1 ||
                                cur_q == $past(cur_q) - 1'b1)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cur_q)); // R10
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cur_q) <= MUTE_IDX); // R6
endmodule

// File: rtl/vol_scale.sv
module vol_scale
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int GAIN_W   = DEF_GAIN_W,
  parameter int FRAC_W   = DEF_FRAC_W
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [GAIN_W-1:0]   gain_i,
  input  logic                       mute_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int PW = SAMPLE_W + GAIN_W + 2;
  localparam logic signed [PW-1:0] SMAX = PW'((64'sd1 <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [PW-1:0] SMIN = -SMAX - 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (FRAC_W - 1));

  logic signed [PW-1:0] prod, shf;

  always_comb begin
    prod = PW'(sample_i) * $signed(PW'(gain_i));
    shf  = (prod + HALF) >>> FRAC_W;
    if (mute_i)          sample_o = '0;
    else if (shf > SMAX) sample_o = SMAX[SAMPLE_W-1:0];
    else if (shf < SMIN) sample_o = SMIN[SAMPLE_W-1:0];
    else                 sample_o = shf[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
  import vol_pkg::*;
#(
  parameter int  SAMPLE_W   = DEF_SAMPLE_W,
  parameter int  CODE_W     = DEF_CODE_W,
  parameter int  GAIN_W     = DEF_GAIN_W,
  parameter int  FRAC_W     = DEF_FRAC_W,
  parameter int  UNITY_CODE = DEF_UNITY,
  parameter int  FLOOR_CODE = DEF_FLOOR,
  parameter int  MUTE_CODE  = DEF_MUTE,
  parameter real STEP_DB    = DEF_STEP_DB
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] left_i,
  input  logic signed [SAMPLE_W-1:0] right_i,
  input  logic [2*CODE_W-1:0]        vol_word_i,
  input  logic                       ramp_en_i,
  output logic                       valid_o,
  output logic signed [SAMPLE_W-1:0] left_o,
  output logic signed [SAMPLE_W-1:0] right_o
);
  localparam int NCH       = 2;
  localparam int FLOOR_IDX = FLOOR_CODE - UNITY_CODE;
  localparam int MUTE_IDX  = FLOOR_IDX + 1;
  localparam int IDX_W     = $clog2(MUTE_IDX + 1);

  logic signed [SAMPLE_W-1:0] smp_in [NCH];
  logic signed [SAMPLE_W-1:0] smp_sc [NCH];
  logic signed [SAMPLE_W-1:0] smp_q  [NCH];

  assign smp_in[0] = left_i;
  assign smp_in[1] = right_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [IDX_W-1:0]  idx;
    logic [GAIN_W-1:0] gain;
    logic              mute;

    vol_ramp #(
      .CODE_W(CODE_W), .UNITY_CODE(UNITY_CODE), .FLOOR_CODE(FLOOR_CODE),
      .MUTE_CODE(MUTE_CODE), .FLOOR_IDX(FLOOR_IDX), .MUTE_IDX(MUTE_IDX), .IDX_W(IDX_W)
    ) u_ramp (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ramp_en_i(ramp_en_i),
      .code_i(vol_word_i[ch*CODE_W +: CODE_W]), .idx_o(idx)
    );

    vol_gain_lut #(
      .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .STEPS(FLOOR_IDX + 1),
      .STEP_DB(STEP_DB), .IDX_W(IDX_W)
    ) u_lut (
      .idx_i(idx), .gain_o(gain), .mute_o(mute)
    );

    vol_scale #(
      .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)
    ) u_scale (
      .sample_i(smp_in[ch]), .gain_i(gain), .mute_i(mute), .sample_o(smp_sc[ch])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      smp_q[ch] <= '0;
      else if (valid_i) smp_q[ch] <= smp_sc[ch];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign left_o  = smp_q[0];
  assign right_o = smp_q[1];

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R11
  AST_VALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R11
  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ramp_en_i && int'(vol_word_i[CODE_W-1:0]) >= MUTE_CODE) |=> left_o == '0); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(left_o) && $stable(right_o))); // R10
endmodule

// File: tb/stereo_vol_ramp_bench.sv
module stereo_vol_ramp_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic valid_i = 0;
  logic signed [15:0] left_i = 0, right_i = 0;
  logic [15:0] vol_word = 16'h3C3C;
  logic ramp_en = 0;
  logic valid_o;
  logic signed [15:0] left_o, right_o;

  int n_tests = 0, n_fail = 0;
  int cur [2];
  bit done = 0;

  always #4 clk = ~clk;

  stereo_vol_ramp u_stereo_vol_ramp (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
    .vol_word_i(vol_word), .ramp_en_i(ramp_en), .valid_o(valid_o),
    .left_o(left_o), .right_o(right_o)
  );

  function automatic int tgt_of(int c);
    if (c < 'h3C) return 0;        // R4
    if (c >= 'hFC) return 181;     // R6
    if (c > 'hF0) return 180;      // R5
    return c - 'h3C;
  endfunction

  function automatic longint exp_of(int x, int idx);
    longint g, p;
    if (idx == 181) return 0;
    g = longint'($rtoi(32768.0 * (10.0 ** (-(0.5017 * idx) / 20.0)) + 0.5));
    p = (longint'(x) * g + 16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int l, int r, logic [15:0] w, logic ren, string tag);
    longint el, er;
    @(negedge clk);
    left_i = 16'(l); right_i = 16'(r); vol_word = w; ramp_en = ren; valid_i = 1;
    for (int ch = 0; ch < 2; ch++) begin
      int t;
      t = tgt_of(int'(ch == 0 ? w[7:0] : w[15:8]));
      if (!ren) cur[ch] = t;
      else if (cur[ch] < t) cur[ch]++;
      else if (cur[ch] > t) cur[ch]--;
    end
    el = exp_of(l, cur[0]);
    er = exp_of(r, cur[1]);
    @(negedge clk);
    valid_i = 0;
    check({tag, "/R11 valid"}, valid_o, 1);
    check({tag, " left"}, left_o, el);
    check({tag, " right"}, right_o, er);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int samples [6] = '{32767, -32768, 1000, -1, 12345, -20001};
    cur[0] = 0; cur[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 valid_o reset", valid_o, 0);
    check("R1 left_o reset", left_o, 0);
    check("R1 right_o reset", right_o, 0);
    rst_n = 1;
    step(30000, -30000, 16'h3C3C, 1, "R1 first sample");
    check("R1 unity pass", left_o, 30000);

    // jump sweep over every code, different code per channel (R2..R7)
    for (int c = 0; c < 256; c++) begin
      for (int s = 0; s < 6; s++)
        step(samples[s], samples[5 - s], {8'(255 - c), 8'(c)}, 0, "R2/R3/R4/R5/R6/R7 sweep");
    end
    check("R6 mute left last", left_o, 0);

    // ramp out of mute toward 0 dB (R9, R8)
    step(20000, 20000, 16'h3C00, 1, "R9 leave mute");
    check("R9 first step -90dB", left_o, exp_of(20000, 180));
    for (int k = 0; k < 185; k++)
      step(20000 - k * 100, -k * 150, 16'h3C00, 1, "R8 ramp up");
    // ramp into mute with same-cycle reversals (R8, R9)
    for (int k = 0; k < 200; k++)
      step(32767 - k, -32768 + k, 16'hFFFE, 1, "R8/R9 ramp down");
    for (int k = 0; k < 40; k++)
      step(16000, -16000, (k % 3 == 0) ? 16'h4060 : 16'hF0FD, k[0], "R7/R8 collide");

    // idle: control changes without strobe (R10)
    step(5000, -5000, 16'h5050, 0, "R10 prime");
    begin
      longint hl, hr;
      hl = left_o; hr = right_o;
      @(negedge clk); vol_word = 16'hFFFF; ramp_en = 0;
      repeat (4) @(negedge clk);
      vol_word = 16'h0000;
      @(negedge clk);
      check("R10 left hold", left_o, hl);
      check("R10 right hold", right_o, hr);
      check("R11 valid idle", valid_o, 0);
    end
    step(5000, -5000, 16'h5A46, 1, "R10 one step after idle");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule